// File: doc/BRIEF.md
# T1 Pulse Density Monitor and Enforcer

This block sits in the bit-serial line path of a T1 port. It watches the transmit stream and the receive stream, one bit per strobe, and checks each against two density rules. The first rule is a zero-run limit: a stream may never carry more than fifteen zeros in a row. The second rule is a family of nested sliding windows: for every N from 1 to 23, any 8·(N+1) consecutive bits must hold at least N ones, so the longest window spans 192 bits. Each stream has its own sticky violation flag, which software or a neighbouring block clears with a pulse.

On the transmit side an enforcer can be switched on. When it is on, the block replaces a transmit zero with a one whenever sending the zero would break either rule at that bit. The transmit monitor always records the bit actually sent. Switch the enforcer off when the line coding already guarantees density, as B8ZS does.

Top module: `pulse_density_guard`

## Requirements
- R1: A stream whose zero-run reaches 16 consecutive zeros sets its flag on the strobe that carries the 16th zero. A run of 15 zeros followed by a one does not set it.
- R2: For each N in 1..23, a full window of the last 8·(N+1) bits holding fewer than N ones sets the flag on the strobe that completes that window.
- R3: After reset, a window is judged only once 8·(N+1) bits have been taken. A window that is not yet full never sets a flag.
- R4: The transmit and receive streams are checked independently. Each has its own flag and its own clear input, and neither acts on the other.
- R5: A flag stays set until a clear pulse for its stream. A clear with no violation on the same cycle leaves the flag at 0 after that edge. A violation on the clear cycle leaves the flag at 1.
- R6: With the enforcer on from reset, the transmitted stream never breaks either rule, so the transmit flag stays 0 for any input data.
- R7: With the enforcer on, txOut equals txIn except that a 0 becomes 1 when sending a 0 would break either rule at that bit. A 1 is never changed to 0. txOut follows the inputs in the same cycle, with no register.
- R8: With the enforcer off, txOut equals txIn.
- R9: Bits are taken only on cycles with bitEn high. On other cycles the monitor state and the flags do not change, except through a clear.
- R10: After reset both flags read 0 and both histories are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Strobe: the current bits are taken on this edge |
| txIn | input | 1 | Transmit data bit before enforcement |
| rxIn | input | 1 | Receive data bit |
| enforceEn | input | 1 | 1 = enforcer on, 0 = transmit data passes unchanged |
| txFlagClr | input | 1 | Clear pulse for the transmit violation flag |
| rxFlagClr | input | 1 | Clear pulse for the receive violation flag |
| txOut | output | 1 | Transmitted bit, after enforcement |
| txViolFlag | output | 1 | Sticky transmit violation flag |
| rxViolFlag | output | 1 | Sticky receive violation flag |

## Verification
A wrong ones-count, a wrong fill count or a wrong history bit in either monitor shows at the ports as soon as a window boundary is crossed. The flag rises one strobe early or late, or it fails to rise at the bit where the rule breaks. On the transmit side the same fault shows within the same cycle as a forced one in the wrong place on txOut. The bench therefore compares txOut on every bit and both flags after every run against a reference that counts windows from scratch. It also drives sparse patterns that fall just inside and just outside the thresholds.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  // Per-stream command from control to a stream datapath
  typedef struct packed {
    logic shift;   // take one bit this edge
    logic bitVal;  // the bit recorded in the history
  } pdm_strobe_t;
endpackage

// File: rtl/pdm_stream_path.sv
module pdm_stream_path
  import pdm_pkg::*;
#(
  parameter int ZERO_RUN_MAX = 15,
  parameter int NUM_WINDOWS  = 23,
  parameter int WINDOW_STEP  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  pdm_strobe_t strobe,
  output logic        riskIfZero,
  output logic        riskIfOne
);
  localparam int HIST_LEN = WINDOW_STEP * (NUM_WINDOWS + 1);
  localparam int CNT_W    = $clog2(HIST_LEN + 1);
  localparam int RUN_W    = $clog2(ZERO_RUN_MAX + 2);

  logic [HIST_LEN-1:0]    hist;
  logic [CNT_W-1:0]       fill;
  logic [RUN_W-1:0]       zeroRun;
  logic [NUM_WINDOWS-1:0] shortIfZero;
  logic [NUM_WINDOWS-1:0] shortIfOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= '0;
      fill    <= '0;
      zeroRun <= '0;
    end else if (strobe.shift) begin
      hist <= {hist[HIST_LEN-2:0], strobe.bitVal};
      if (fill != CNT_W'(HIST_LEN)) fill <= fill + 1'b1;
      if (strobe.bitVal) zeroRun <= '0;
      else if (zeroRun <= RUN_W'(ZERO_RUN_MAX)) zeroRun <= zeroRun + 1'b1;
    end
  end

  // One running ones-count per window length
  for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
    localparam int REQ = w + 1;
    localparam int LEN = WINDOW_STEP * (w + 2);
    logic             leaving;
    logic             willFill;
    logic [CNT_W-1:0] keep;
    logic [CNT_W-1:0] onesCnt;

    assign leaving  = hist[LEN-1];
    assign willFill = (fill >= CNT_W'(LEN - 1));
    assign keep     = onesCnt - CNT_W'(leaving);
    assign shortIfZero[w] = willFill && (keep < CNT_W'(REQ));
    assign shortIfOne[w]  = willFill && (keep < CNT_W'(REQ - 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) onesCnt <= '0;
      else if (strobe.shift) onesCnt <= keep + CNT_W'(strobe.bitVal);
    end

    // R2: a count never exceeds the length of its window
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
      onesCnt <= CNT_W'(LEN));
  end

  assign riskIfZero = (zeroRun >= RUN_W'(ZERO_RUN_MAX)) || (|shortIfZero);
  assign riskIfOne  = |shortIfOne;

  assert_run_resets_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift && strobe.bitVal |=> zeroRun == '0);
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(HIST_LEN));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(fill) && $stable(zeroRun));
endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        txIn,
  input  logic        rxIn,
  input  logic        enforceEn,
  input  logic        txFlagClr,
  input  logic        rxFlagClr,
  input  logic        txRiskIfZero,
  input  logic        txRiskIfOne,
  input  logic        rxRiskIfZero,
  input  logic        rxRiskIfOne,
  output pdm_strobe_t txStrobe,
  output pdm_strobe_t rxStrobe,
  output logic        txOut,
  output logic        txViolFlag,
  output logic        rxViolFlag
);
  logic txBit;
  logic txViol;
  logic rxViol;

  // Substitute a one only where a zero would break a rule
  assign txBit  = txIn || (enforceEn && txRiskIfZero);
  assign txOut  = txBit;
  assign txViol = bitEn && (txBit ? txRiskIfOne : txRiskIfZero);
  assign rxViol = bitEn && (rxIn ? rxRiskIfOne : rxRiskIfZero);

  assign txStrobe = '{shift: bitEn, bitVal: txBit};
  assign rxStrobe = '{shift: bitEn, bitVal: rxIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txViolFlag <= 1'b0;
      rxViolFlag <= 1'b0;
    end else begin
      txViolFlag <= (txViolFlag && !txFlagClr) || txViol;
      rxViolFlag <= (rxViolFlag && !rxFlagClr) || rxViol;
    end
  end

  assert_tx_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    txViolFlag && !txFlagClr |=> txViolFlag);
  assert_rx_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxViolFlag && !rxFlagClr |=> rxViolFlag);
  assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxFlagClr && !rxViol |=> !rxViolFlag);
  assert_only_adds_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    txIn |-> txOut);
  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enforceEn |-> txOut == txIn);
  assert_no_rise_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> !$rose(txViolFlag) && !$rose(rxViolFlag));
endmodule

// File: rtl/pulse_density_guard.sv
module pulse_density_guard
  import pdm_pkg::*;
#(
  parameter int ZERO_RUN_MAX = 15,
  parameter int NUM_WINDOWS  = 23,
  parameter int WINDOW_STEP  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic txIn,
  input  logic rxIn,
  input  logic enforceEn,
  input  logic txFlagClr,
  input  logic rxFlagClr,
  output logic txOut,
  output logic txViolFlag,
  output logic rxViolFlag
);
  localparam int NUM_STREAMS = 2;  // index 0 = transmit, 1 = receive

  pdm_strobe_t strobes   [NUM_STREAMS];
  logic        riskZero  [NUM_STREAMS];
  logic        riskOne   [NUM_STREAMS];

  pdm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .bitEn        (bitEn),
    .txIn         (txIn),
    .rxIn         (rxIn),
    .enforceEn    (enforceEn),
    .txFlagClr    (txFlagClr),
    .rxFlagClr    (rxFlagClr),
    .txRiskIfZero (riskZero[0]),
    .txRiskIfOne  (riskOne[0]),
    .rxRiskIfZero (riskZero[1]),
    .rxRiskIfOne  (riskOne[1]),
    .txStrobe     (strobes[0]),
    .rxStrobe     (strobes[1]),
    .txOut        (txOut),
    .txViolFlag   (txViolFlag),
    .rxViolFlag   (rxViolFlag)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    pdm_stream_path #(
      .ZERO_RUN_MAX (ZERO_RUN_MAX),
      .NUM_WINDOWS  (NUM_WINDOWS),
      .WINDOW_STEP  (WINDOW_STEP)
    ) u_path (
      .clk        (clk),
      .rstN       (rstN),
      .strobe     (strobes[s]),
      .riskIfZero (riskZero[s]),
      .riskIfOne  (riskOne[s])
    );
  end
endmodule

// File: tb/tb_pulse_density_guard.sv
module tb_pulse_density_guard;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, txIn = 1'b0, rxIn = 1'b0, enforceEn = 1'b0;
  logic txFlagClr = 1'b0, rxFlagClr = 1'b0;
  logic txOut, txViolFlag, rxViolFlag;

  int total = 0;
  int bad = 0;

  // reference model state
  logic mTx [MAXB];
  logic mRx [MAXB];
  int   mN = 0;
  logic expTx = 1'b0, expRx = 1'b0;
  logic lastOut;

  typedef struct packed {
    int   period;   // one '1' every period bits
    int   nbits;
    logic enf;
    logic expRxF;   // hand-derived receive flag after the run
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8,   300, 1'b0, 1'b0},   // exactly N+1 ones per window
    '{9,   300, 1'b0, 1'b1},   // 8 ones in an 80-bit window
    '{16,  300, 1'b0, 1'b1},   // 1 one in a 24-bit window
    '{17,  300, 1'b1, 1'b1},   // run of 16 zeros
    '{9,   300, 1'b1, 1'b1},
    '{1,   200, 1'b0, 1'b0}    // all ones
  };

  always #4 clk = ~clk;

  pulse_density_guard dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .txIn(txIn), .rxIn(rxIn),
    .enforceEn(enforceEn), .txFlagClr(txFlagClr), .rxFlagClr(rxFlagClr),
    .txOut(txOut), .txViolFlag(txViolFlag), .rxViolFlag(rxViolFlag)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic hb(input logic isTx, input int i);
    return isTx ? mTx[i] : mRx[i];
  endfunction

  // Does appending nb to the stream break a rule at this bit?
  function automatic logic modelViol(input logic isTx, input logic nb);
    int run;
    logic more;
    run = nb ? 0 : 1;
    more = !nb;
    for (int i = mN - 1; i >= 0 && more; i--) begin
      if (hb(isTx, i)) more = 1'b0;
      else run++;
    end
    if (run > 15) return 1'b1;
    for (int n = 1; n <= 23; n++) begin
      int len;
      int ones;
      len = 8 * (n + 1);
      if (mN + 1 >= len) begin
        ones = nb;
        for (int j = mN - len + 1; j < mN; j++) ones += hb(isTx, j);
        if (ones < n) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0; txFlagClr = 1'b0; rxFlagClr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mN = 0; expTx = 1'b0; expRx = 1'b0;
  endtask

  task automatic sendBit(input logic t, input logic r, input logic ct, input logic cr);
    logic expOut, vt, vr;
    @(negedge clk);
    txIn = t; rxIn = r; bitEn = 1'b1; txFlagClr = ct; rxFlagClr = cr;
    expOut = t | (enforceEn & modelViol(1'b1, 1'b0));
    #1;
    lastOut = txOut;
    check(txOut === expOut, enforceEn ? "R7" : "R8", txOut, expOut);
    vt = modelViol(1'b1, expOut);
    vr = modelViol(1'b0, r);
    expTx = (expTx & ~ct) | vt;
    expRx = (expRx & ~cr) | vr;
    if (mN < MAXB) begin
      mTx[mN] = expOut; mRx[mN] = r; mN++;
    end
    @(posedge clk);
    #1;
    bitEn = 1'b0; txFlagClr = 1'b0; rxFlagClr = 1'b0;
  endtask

  task automatic checkFlags(input string req);
    check(txViolFlag === expTx, req, txViolFlag, expTx);
    check(rxViolFlag === expRx, req, rxViolFlag, expRx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R10: reset state
    @(negedge clk);
    check(txViolFlag === 1'b0, "R10", txViolFlag, 0);
    check(rxViolFlag === 1'b0, "R10", rxViolFlag, 0);
    txIn = 1'b1; #1;
    check(txOut === 1'b1, "R8", txOut, 1);
    txIn = 1'b0;

    // Table walk: sparse periodic patterns on both streams
    for (int v = 0; v < 6; v++) begin
      doReset();
      enforceEn = VECS[v].enf;
      for (int i = 0; i < VECS[v].nbits; i++) begin
        logic b;
        b = ((i + 1) % VECS[v].period) == 0;
        sendBit(b, b, 1'b0, 1'b0);
      end
      checkFlags("R2");
      check(rxViolFlag === VECS[v].expRxF, "R2", rxViolFlag, VECS[v].expRxF);
      if (VECS[v].enf) check(txViolFlag === 1'b0, "R6", txViolFlag, 0);
    end
    enforceEn = 1'b0;

    // R1 and R3: a one then 15 zeros is clean, the 16th zero is not
    doReset();
    sendBit(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    check(rxViolFlag === 1'b0, "R1", rxViolFlag, 0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    check(rxViolFlag === 1'b1, "R1", rxViolFlag, 1);
    check(txViolFlag === 1'b1, "R1", txViolFlag, 1);

    // R3 and R9: 15 zeros from reset, then idle cycles, then one more
    doReset();
    for (int i = 0; i < 15; i++) sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(rxViolFlag === 1'b0, "R3", rxViolFlag, 0);
    check(txViolFlag === 1'b0, "R9", txViolFlag, 0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    check(rxViolFlag === 1'b1, "R9", rxViolFlag, 1);

    // R5 and R4: clear receive only, then clear with a violation
    @(negedge clk);
    rxFlagClr = 1'b1;
    @(posedge clk); #1;
    rxFlagClr = 1'b0; expRx = 1'b0;
    check(rxViolFlag === 1'b0, "R5", rxViolFlag, 0);
    check(txViolFlag === 1'b1, "R4", txViolFlag, 1);
    sendBit(1'b0, 1'b0, 1'b0, 1'b1);
    check(rxViolFlag === 1'b1, "R5", rxViolFlag, 1);
    sendBit(1'b1, 1'b1, 1'b1, 1'b1);
    checkFlags("R5");

    // R6 and R7: enforcer on, all zeros; first forced one is bit 16
    doReset();
    enforceEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sendBit(1'b0, 1'b0, 1'b0, 1'b0);
      if (i == 14 || i == 15)
        check(lastOut === (i == 15), "R7", lastOut, (i == 15));
    end
    for (int i = 0; i < 400; i++) sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    check(txViolFlag === 1'b0, "R6", txViolFlag, 0);
    check(rxViolFlag === 1'b1, "R4", rxViolFlag, 1);

    // Random sparse data, enforcer off then on
    doReset();
    enforceEn = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if (i == 750) enforceEn = 1'b1;
      sendBit(($urandom % 6) == 0, ($urandom % 7) == 0,
              ($urandom % 97) == 0, ($urandom % 89) == 0);
      if (i % 250 == 249) checkFlags("R2");
    end
    enforceEn = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule